// File: doc/BRIEF.md
# Command-Driven Video Frame Unpacker

This block sits behind a word aligner on the receive side of a serial video link. Each cycle it may take one aligned 32-bit word and a flag that marks the word's low byte as a control character. From that stream it rebuilds a raster video stream: a 16-bit pixel bus with a valid strobe, a field sync level, and the number of the line being delivered.

The transmitter marks frame and line boundaries with 32-bit command words. A command word always carries the control flag and has 0xBC in its low byte, and the command number sits in bits 15:8 on top of the fixed pattern 0x5500_00BC. Commands raise and drop field sync, open and close lines, pad blanking, and close the frame. Inside an open line, the first data word is the line number. Every later data word carries two pixels.

Each payload word becomes two pixels on consecutive cycles. The input therefore stalls for one cycle after each accepted payload word, and `inReady` shows when the block can take a word. Two conditions count as faults: a line restarted before it was closed, and an unknown command inside a line. The first increments a saturating counter. The second sets a sticky flag.

Top module: `vid_cmd_unpacker`

## Requirements
- R1: After reset `fieldSync`, `pixValid`, `frameEnd` and `errFlag` are 0, `lineNum` and `errCount` are 0, and `inReady` is 1.
- R2: A word is accepted when `inValid` and `inReady` are both high. An accepted command 0x550000BC sets `fieldSync` on the next cycle, and an accepted command 0x550001BC clears it on the next cycle.
- R3: The filler commands 0x550002BC and 0x550003BC change no output. A filler inside a line leaves the line open.
- R4: After the line-open command 0x550004BC, the next accepted data word is the line number. Its low `LINE_W` bits appear on `lineNum` one cycle after acceptance, and that word produces no pixel.
- R5: Every later data word in the line gives two pixels. Bits 15:0 appear on `pixData` with `pixValid` high one cycle after acceptance, and bits 31:16 appear with `pixValid` high the cycle after that. `inReady` is 0 during the first of these two cycles.
- R6: The line-close command 0x550005BC ends the line. Data words that follow it produce no pixel until a new line-open command and line number have been received.
- R7: The frame-tail commands 0x550006BC and 0x550007BC both end any open line. 0x550007BC also pulses `frameEnd` for one cycle, one cycle after acceptance.
- R8: A word is a command only when `inIsK` is 1 and bits 7:0 equal 0xBC. A command pattern with `inIsK` at 0 is payload, and so is a word with `inIsK` at 1 whose low byte is not 0xBC.
- R9: A line-open command received while a line is open drops the partial line, waits for a new line number, and increments `errCount`. The counter saturates at its all-ones value.
- R10: A word that is a command (R8) but matches none of the eight codes sets `errFlag` if a line is open, and `errFlag` then stays set until reset. Such a word changes nothing else. Outside a line it is ignored completely.
- R11: Data words received while no line is open produce no pixel and do not change `lineNum`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input word present |
| inIsK | input | 1 | Low byte of the input word is a control character |
| inData | input | 32 | Aligned input word |
| inReady | output | 1 | Block can accept a word this cycle |
| pixData | output | 16 | Recovered pixel |
| pixValid | output | 1 | Pixel on `pixData` is valid |
| fieldSync | output | 1 | Restored field sync level |
| lineNum | output | LINE_W | Number of the current line |
| frameEnd | output | 1 | One-cycle pulse on the final frame-tail command |
| errCount | output | ERR_W | Saturating count of restarted lines |
| errFlag | output | 1 | Sticky flag for unknown commands inside a line |

## Verification
The main stream is tried with words whose low half and high half differ, so that a swapped or repeated half shows up on the pixel bus. The same command pattern is sent both with and without the control flag, and with the flag set on a word whose low byte is not 0xBC, which separates decoding by flag from decoding by value. Payload words are placed before the first line open, after a line close and after a frame tail, to show that the line state, and not just the last command seen, gates the pixels. A long run of repeated line opens pushes the error counter past its limit, and a filler and an unknown command placed mid-line show that neither of them closes the line.

// File: rtl/vidunpack_pkg.sv
package vidunpack_pkg;

  localparam int WORD_W = 32;
  localparam int PIX_W  = WORD_W / 2;
  localparam int N_CMD  = 8;

  // Command words share this pattern; the command number sits in bits 15:8.
  localparam logic [WORD_W-1:0] CMD_BASE = 32'h5500_00BC;
  localparam logic [7:0]        K_COMMA  = 8'hBC;

  typedef enum logic [2:0] {
    C_FRAME_OPEN  = 3'd0,
    C_FRAME_SHUT  = 3'd1,
    C_FILL_A      = 3'd2,
    C_FILL_B      = 3'd3,
    C_LINE_OPEN   = 3'd4,
    C_LINE_CLOSE  = 3'd5,
    C_TAIL_A      = 3'd6,
    C_TAIL_B      = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NUM  = 2'd1,
    ST_PAY  = 2'd2
  } lineState_e;

  // Strobes that the control unit sends to the datapath.
  typedef struct packed {
    logic setSync;
    logic clrSync;
    logic loadLine;
    logic pushPix;
    logic bumpErr;
    logic flagErr;
    logic frameDone;
  } strobes_t;

endpackage

// File: rtl/vu_ctrl.sv
module vu_ctrl
  import vidunpack_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inIsK,
  input  logic [WORD_W-1:0] inData,
  input  logic              inReady,
  output strobes_t          st
);

  logic [N_CMD-1:0] cmdHit;
  logic             accept;
  logic             isCmd;
  logic             lineOpen;
  lineState_e       stateQ, stateD;

  // One comparator per command code.
  for (genvar g = 0; g < N_CMD; g++) begin : g_cmd
    localparam logic [WORD_W-1:0] CODE = CMD_BASE | (WORD_W'(g) << 8);
    assign cmdHit[g] = (inData == CODE);
  end

  assign accept   = inValid && inReady;
  assign isCmd    = inIsK && (inData[7:0] == K_COMMA);
  assign lineOpen = (stateQ != ST_IDLE);

  always_comb begin
    st     = '0;
    stateD = stateQ;
    if (accept) begin
      if (isCmd) begin
        if (cmdHit[C_FRAME_OPEN]) begin
          st.setSync = 1'b1;
        end else if (cmdHit[C_FRAME_SHUT]) begin
          st.clrSync = 1'b1;
        end else if (cmdHit[C_FILL_A] || cmdHit[C_FILL_B]) begin
          stateD = stateQ;
        end else if (cmdHit[C_LINE_OPEN]) begin
          st.bumpErr = lineOpen;
          stateD     = ST_NUM;
        end else if (cmdHit[C_LINE_CLOSE] || cmdHit[C_TAIL_A]) begin
          stateD = ST_IDLE;
        end else if (cmdHit[C_TAIL_B]) begin
          st.frameDone = 1'b1;
          stateD       = ST_IDLE;
        end else begin
          st.flagErr = lineOpen;
        end
      end else begin
        case (stateQ)
          ST_NUM: begin
            st.loadLine = 1'b1;
            stateD      = ST_PAY;
          end
          ST_PAY:  st.pushPix = 1'b1;
          default: stateD = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // Pixels are only pushed once a line number has been taken.
  AST_PUSH_AFTER_NUMBER: assert property (@(posedge clk) disable iff (!rstN)
    st.pushPix |-> (stateQ == ST_PAY) && !isCmd); // R5

  // A line close leaves the block outside any line.
  AST_CLOSE_GOES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (accept && isCmd && cmdHit[C_LINE_CLOSE]) |=> !lineOpen); // R6

endmodule

// File: rtl/vu_datapath.sv
module vu_datapath
  import vidunpack_pkg::*;
#(
  parameter int LINE_W = 16,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          st,
  input  logic [WORD_W-1:0] word,
  output logic              inReady,
  output logic [PIX_W-1:0]  pixData,
  output logic              pixValid,
  output logic              fieldSync,
  output logic [LINE_W-1:0] lineNum,
  output logic              frameEnd,
  output logic [ERR_W-1:0]  errCount,
  output logic              errFlag
);

  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

  logic [PIX_W-1:0] highHold;
  logic             pendHigh;

  assign inReady = !pendHigh;

  // Split each payload word into two pixels.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixData  <= '0;
      pixValid <= 1'b0;
      highHold <= '0;
      pendHigh <= 1'b0;
    end else if (pendHigh) begin
      pixData  <= highHold;
      pixValid <= 1'b1;
      pendHigh <= 1'b0;
    end else if (st.pushPix) begin
      pixData  <= word[PIX_W-1:0];
      highHold <= word[WORD_W-1:PIX_W];
      pixValid <= 1'b1;
      pendHigh <= 1'b1;
    end else begin
      pixValid <= 1'b0;
    end
  end

  // Field sync level, line number and frame-end pulse.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fieldSync <= 1'b0;
      lineNum   <= '0;
      frameEnd  <= 1'b0;
    end else begin
      frameEnd <= st.frameDone;
      if (st.setSync)       fieldSync <= 1'b1;
      else if (st.clrSync)  fieldSync <= 1'b0;
      if (st.loadLine)      lineNum <= word[LINE_W-1:0];
    end
  end

  // Fault reporting.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCount <= '0;
      errFlag  <= 1'b0;
    end else begin
      if (st.bumpErr && (errCount != ERR_MAX)) errCount <= errCount + 1'b1;
      if (st.flagErr) errFlag <= 1'b1;
    end
  end

  AST_PIX_LOW_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    st.pushPix |=> pixValid && (pixData == $past(word[PIX_W-1:0]))); // R5

  AST_PIX_HIGH_SECOND: assert property (@(posedge clk) disable iff (!rstN)
    st.pushPix |=> ##1 (pixValid && (pixData == $past(word[WORD_W-1:PIX_W], 2)))); // R5

  AST_SYNC_RAISED: assert property (@(posedge clk) disable iff (!rstN)
    st.setSync |=> fieldSync); // R2

  AST_ERRCNT_NO_DROP: assert property (@(posedge clk) disable iff (!rstN)
    errCount >= $past(errCount)); // R9

  AST_ERRFLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag); // R10

endmodule

// File: rtl/vid_cmd_unpacker.sv
module vid_cmd_unpacker
  import vidunpack_pkg::*;
#(
  parameter int LINE_W = 16,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inIsK,
  input  logic [31:0]       inData,
  output logic              inReady,
  output logic [15:0]       pixData,
  output logic              pixValid,
  output logic              fieldSync,
  output logic [LINE_W-1:0] lineNum,
  output logic              frameEnd,
  output logic [ERR_W-1:0]  errCount,
  output logic              errFlag
);

  strobes_t strobes;

  vu_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inIsK   (inIsK),
    .inData  (inData),
    .inReady (inReady),
    .st      (strobes)
  );

  vu_datapath #(
    .LINE_W (LINE_W),
    .ERR_W  (ERR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (strobes),
    .word      (inData),
    .inReady   (inReady),
    .pixData   (pixData),
    .pixValid  (pixValid),
    .fieldSync (fieldSync),
    .lineNum   (lineNum),
    .frameEnd  (frameEnd),
    .errCount  (errCount),
    .errFlag   (errFlag)
  );

endmodule

// File: tb/tb_vid_cmd_unpacker.sv
module tb_vid_cmd_unpacker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inIsK = 1'b0;
  logic [31:0] inData = '0;
  logic        inReady;
  logic [15:0] pixData;
  logic        pixValid;
  logic        fieldSync;
  logic [15:0] lineNum;
  logic        frameEnd;
  logic [7:0]  errCount;
  logic        errFlag;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  vid_cmd_unpacker #(.LINE_W(16), .ERR_W(8)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inIsK(inIsK), .inData(inData),
    .inReady(inReady), .pixData(pixData), .pixValid(pixValid),
    .fieldSync(fieldSync), .lineNum(lineNum), .frameEnd(frameEnd),
    .errCount(errCount), .errFlag(errFlag)
  );

  typedef struct packed {
    logic        k;
    logic [31:0] word;
    logic        v;
    logic        s;
    logic [15:0] line;
    logic        fe;
    logic        ef;
    logic [7:0]  ec;
    logic [3:0]  req;
  } vec_t;

  // k, word, valid, sync, lineNum, frameEnd, errFlag, errCount, requirement
  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 32'h550000BC, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 8'd0, 4'd2},  // R2 sync up
    '{1'b1, 32'h550002BC, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 8'd0, 4'd3},  // R3 filler
    '{1'b1, 32'h550003BC, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 8'd0, 4'd3},  // R3 filler
    '{1'b0, 32'h12345678, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 8'd0, 4'd11}, // R11 no line
    '{1'b1, 32'h550004BC, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 8'd0, 4'd4},  // R4 line open
    '{1'b0, 32'h0000002A, 1'b0, 1'b1, 16'h002A, 1'b0, 1'b0, 8'd0, 4'd4},  // R4 number
    '{1'b0, 32'hBBBBAAAA, 1'b1, 1'b1, 16'h002A, 1'b0, 1'b0, 8'd0, 4'd5},  // R5
    '{1'b0, 32'h22221111, 1'b1, 1'b1, 16'h002A, 1'b0, 1'b0, 8'd0, 4'd5},  // R5
    '{1'b1, 32'h550002BC, 1'b0, 1'b1, 16'h002A, 1'b0, 1'b0, 8'd0, 4'd3},  // R3 mid-line
    '{1'b0, 32'h44443333, 1'b1, 1'b1, 16'h002A, 1'b0, 1'b0, 8'd0, 4'd3},  // R3 line still open
    '{1'b0, 32'h550004BC, 1'b1, 1'b1, 16'h002A, 1'b0, 1'b0, 8'd0, 4'd8},  // R8 no flag
    '{1'b1, 32'h12345678, 1'b1, 1'b1, 16'h002A, 1'b0, 1'b0, 8'd0, 4'd8},  // R8 not BC
    '{1'b1, 32'h550005BC, 1'b0, 1'b1, 16'h002A, 1'b0, 1'b0, 8'd0, 4'd6},  // R6 close
    '{1'b0, 32'h66665555, 1'b0, 1'b1, 16'h002A, 1'b0, 1'b0, 8'd0, 4'd6},  // R6 after close
    '{1'b1, 32'h550009BC, 1'b0, 1'b1, 16'h002A, 1'b0, 1'b0, 8'd0, 4'd10}, // R10 outside
    '{1'b1, 32'h550004BC, 1'b0, 1'b1, 16'h002A, 1'b0, 1'b0, 8'd0, 4'd4},
    '{1'b0, 32'h00000007, 1'b0, 1'b1, 16'h0007, 1'b0, 1'b0, 8'd0, 4'd4},
    '{1'b0, 32'h88887777, 1'b1, 1'b1, 16'h0007, 1'b0, 1'b0, 8'd0, 4'd5},
    '{1'b1, 32'h550004BC, 1'b0, 1'b1, 16'h0007, 1'b0, 1'b0, 8'd1, 4'd9},  // R9 restart
    '{1'b0, 32'h00000008, 1'b0, 1'b1, 16'h0008, 1'b0, 1'b0, 8'd1, 4'd9},  // R9 new number
    '{1'b0, 32'hAAAA9999, 1'b1, 1'b1, 16'h0008, 1'b0, 1'b0, 8'd1, 4'd5},
    '{1'b1, 32'h5500FFBC, 1'b0, 1'b1, 16'h0008, 1'b0, 1'b1, 8'd1, 4'd10}, // R10 inside
    '{1'b0, 32'hCCCCBBBB, 1'b1, 1'b1, 16'h0008, 1'b0, 1'b1, 8'd1, 4'd10}, // R10 line kept
    '{1'b1, 32'h550006BC, 1'b0, 1'b1, 16'h0008, 1'b0, 1'b1, 8'd1, 4'd7},  // R7 tail A
    '{1'b0, 32'hDDDDCCCC, 1'b0, 1'b1, 16'h0008, 1'b0, 1'b1, 8'd1, 4'd7},  // R7 line gone
    '{1'b1, 32'h550007BC, 1'b0, 1'b1, 16'h0008, 1'b1, 1'b1, 8'd1, 4'd7},  // R7 tail B
    '{1'b1, 32'h550001BC, 1'b0, 1'b0, 16'h0008, 1'b0, 1'b1, 8'd1, 4'd2}   // R2 sync down
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic k, input logic [31:0] w);
    @(negedge clk);
    inValid = 1'b1;
    inIsK   = k;
    inData  = w;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic checkReset();
    check("R1", "fieldSync", 32'(fieldSync), 32'd0);
    check("R1", "pixValid",  32'(pixValid),  32'd0);
    check("R1", "frameEnd",  32'(frameEnd),  32'd0);
    check("R1", "errFlag",   32'(errFlag),   32'd0);
    check("R1", "lineNum",   32'(lineNum),   32'd0);
    check("R1", "errCount",  32'(errCount),  32'd0);
    check("R1", "inReady",   32'(inReady),   32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkReset();  // R1

    for (int i = 0; i < NV; i++) begin
      string r;
      r = $sformatf("R%0d", VEC[i].req);
      send(VEC[i].k, VEC[i].word);
      check(r, "pixValid",  32'(pixValid),  32'(VEC[i].v));
      check(r, "fieldSync", 32'(fieldSync), 32'(VEC[i].s));
      check(r, "lineNum",   32'(lineNum),   32'(VEC[i].line));
      check(r, "frameEnd",  32'(frameEnd),  32'(VEC[i].fe));
      check(r, "errFlag",   32'(errFlag),   32'(VEC[i].ef));
      check(r, "errCount",  32'(errCount),  32'(VEC[i].ec));
      if (VEC[i].v) begin
        check(r, "pixData low",  32'(pixData), 32'(VEC[i].word[15:0]));
        check(r, "inReady stall", 32'(inReady), 32'd0);
        @(negedge clk);
        check(r, "pixValid high", 32'(pixValid), 32'd1);
        check(r, "pixData high",  32'(pixData),  32'(VEC[i].word[31:16]));
        check(r, "inReady back",  32'(inReady),  32'd1);
      end
    end

    // R9: repeated line opens saturate the counter; line number is kept.
    send(1'b1, 32'h550004BC);
    for (int n = 0; n < 300; n++) send(1'b1, 32'h550004BC);
    check("R9", "errCount saturated", 32'(errCount), 32'd255);
    check("R9", "lineNum kept", 32'(lineNum), 32'h0008);
    send(1'b0, 32'h00000055);
    check("R9", "lineNum after restart", 32'(lineNum), 32'h0055);
    send(1'b0, 32'hF00D0BAD);
    check("R9", "pixData after restart", 32'(pixData), 32'h0BAD);

    // R1: reset in mid-stream restores the idle state.
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkReset();
    // R11: after reset no line is open.
    send(1'b0, 32'h13572468);
    check("R11", "pixValid after reset", 32'(pixValid), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule